// File: doc/BRIEF.md
# Two-Bank SDRAM Row Timing Tracker

This block sits beside the command path of a two-bank synchronous DRAM controller and checks row timing before commands are issued. On every rising clock edge it samples one command (no-op, activate, read, write, read or write with auto-precharge, precharge) together with a one-bit bank select. For each bank it keeps an open, closed or closing state and saturating cycle counters. From these it tells the scheduler, for each bank, whether an activate, a column command or a precharge would be legal in the current cycle.

A command that breaks a timing rule is reported through a registered violation flag, a code naming the rule and the bank it hit. The bank does not act on that command. The tracker also watches how long each row stays open and reports when a row has been open too long. An auto-precharge command closes its row at the earliest legal cycle without any further command. All timing limits are parameters counted in clock cycles.

Top module: `sdram_row_tracker`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, both banks are closed with the precharge time already met. `act_rdy_o` is 11, `col_rdy_o` and `pre_rdy_o` are 00, and `viol_o` is 0.
- R2: An activate is accepted only by a closed bank whose last precharge began at least T_RP cycles earlier. `act_rdy_o[b]` goes high exactly T_RP cycles after the precharge cycle. An activate to an open or still-closing bank is flagged with code 1 and ignored.
- R3: Two accepted activates, to either bank, are at least T_RRD cycles apart. An activate that comes earlier than that is flagged with code 2 and ignored, and `act_rdy_o` reflects this spacing for both banks.
- R4: A column command (read, write or either auto-precharge form) to an open bank earlier than T_RCD cycles after its activate is flagged with code 5 and ignored. `col_rdy_o[b]` rises exactly T_RCD cycles after the activate.
- R5: A precharge to an open bank earlier than T_RAS_MIN cycles after its activate is flagged with code 3, and the row stays open. `pre_rdy_o[b]` rises exactly T_RAS_MIN cycles after the activate.
- R6: When a row is still open exactly T_RAS_MAX cycles after its activate, the block reports code 4 for that bank once per activation. The row stays open.
- R7: A column command to a closed or closing bank, or to a bank that already has an auto-precharge pending, is flagged with code 6 and ignored.
- R8: A precharge to a closed or closing bank, or to a bank with an auto-precharge pending, does nothing and raises no violation.
- R9: A read or write with auto-precharge accepted in cycle t closes its row in cycle max(t + BURST_LEN, t_act + T_RAS_MIN). From t + 1 the bank shows no column or precharge readiness. Activate readiness returns T_RP cycles after the closing cycle.
- R10: The violation outputs are registered and describe the previous cycle. `viol_code_o` is 0 and `viol_bank_o` is 0 when `viol_o` is 0. A command violation takes priority over an open-too-long report, and bank 0's report takes priority over bank 1's.
- R11: The command encoding on `cmd_i` is 0 no-op, 1 activate, 2 read, 3 write, 4 read with auto-precharge, 5 write with auto-precharge, 6 precharge. Code 7 behaves as a no-op. `bank_i` selects bank 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, commands sampled on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code (see R11) |
| bank_i | input | 1 | Target bank of the command |
| act_rdy_o | output | 2 | Per bank: an activate would be accepted this cycle |
| col_rdy_o | output | 2 | Per bank: a column command would be accepted this cycle |
| pre_rdy_o | output | 2 | Per bank: a precharge would close the row this cycle |
| viol_o | output | 1 | A rule was broken in the previous cycle |
| viol_code_o | output | 3 | Rule broken: 1 precharge time, 2 activate spacing, 3 open too short, 4 open too long, 5 row-to-column, 6 row not open |
| viol_bank_o | output | 1 | Bank the violation refers to |

## Verification
A bank counter that is off by one moves the rising edge of a ready output by one cycle. A per-cycle comparison exposes this in the first cycle it differs, long before any command is rejected. A state that fails to update on an ignored or accepted command shows up later, as a wrong ready level or a wrong violation code one cycle after the next command to that bank. A missed auto-precharge shows up as activate readiness that never returns. A stuck or wrongly prioritised violation register is visible in the cycle after the offending command or the T_RAS_MAX point.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_RDA = 3'd4,
        CMD_WRA = 3'd5,
        CMD_PRE = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        VIO_NONE   = 3'd0,
        VIO_TRP    = 3'd1,
        VIO_TRRD   = 3'd2,
        VIO_RASMIN = 3'd3,
        VIO_RASMAX = 3'd4,
        VIO_TRCD   = 3'd5,
        VIO_CLOSED = 3'd6
    } vio_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_PRECH  = 2'd2
    } bank_st_e;

endpackage

// File: rtl/sdt_rrd_gap.sv
module sdt_rrd_gap #(
    parameter int unsigned T_RRD = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic act_fire_i,
    output logic ok_o
);
    localparam int unsigned RW = $clog2(T_RRD + 1) + 1;
    localparam logic [RW-1:0] SAT_C = {RW{1'b1}};
    localparam logic [RW-1:0] RRD_C = RW'(T_RRD);

    logic [RW-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (gap_q != SAT_C) gap_d = gap_q + 1'b1;
        if (act_fire_i) gap_d = RW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) gap_q <= SAT_C;
        else       gap_q <= gap_d;
    end

    assign ok_o = (gap_q >= RRD_C);

endmodule

// File: rtl/sdt_bank.sv
module sdt_bank
    import sdt_pkg::*;
#(
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RAS_MIN = 8,
    parameter int unsigned T_RAS_MAX = 40,
    parameter int unsigned T_RCD     = 3,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned CW        = 6
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] cmd_i,
    input  logic       sel_i,
    input  logic       rrd_ok_i,
    output logic       act_rdy_o,
    output logic       col_rdy_o,
    output logic       pre_rdy_o,
    output logic [2:0] err_o,
    output logic       act_fire_o,
    output logic       ras_over_o
);
    localparam logic [CW-1:0] SAT_C    = {CW{1'b1}};
    localparam logic [CW-1:0] RP_C     = CW'(T_RP);
    localparam logic [CW-1:0] RP_M1_C  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RCD_C    = CW'(T_RCD);
    localparam logic [CW-1:0] RASMIN_C = CW'(T_RAS_MIN);
    localparam logic [CW-1:0] RASMAX_C = CW'(T_RAS_MAX);
    localparam logic [CW-1:0] BL_M1_C  = CW'(BURST_LEN - 1);
    localparam bank_st_e      CLOSE_ST = (T_RP <= 1) ? BK_IDLE : BK_PRECH;

    typedef struct packed {
        bank_st_e        st;
        logic            ap;
        logic [CW-1:0]   act_cnt;
        logic [CW-1:0]   pre_cnt;
        logic [CW-1:0]   bst_cnt;
    } bank_t;

    bank_t q, d;
    vio_e  err;
    logic  act_fire, start_pre, is_col, is_auto;

    always_comb begin
        d         = q;
        err       = VIO_NONE;
        act_fire  = 1'b0;
        start_pre = 1'b0;
        is_col    = (cmd_i == CMD_RD) || (cmd_i == CMD_WR) ||
                    (cmd_i == CMD_RDA) || (cmd_i == CMD_WRA);
        is_auto   = (cmd_i == CMD_RDA) || (cmd_i == CMD_WRA);

        if (q.act_cnt != SAT_C) d.act_cnt = q.act_cnt + 1'b1;
        if (q.pre_cnt != SAT_C) d.pre_cnt = q.pre_cnt + 1'b1;
        if (q.bst_cnt != '0)    d.bst_cnt = q.bst_cnt - 1'b1;

        if (q.st == BK_PRECH && q.pre_cnt >= RP_M1_C) d.st = BK_IDLE;

        if (sel_i) begin
            if (cmd_i == CMD_ACT) begin
                if (q.st != BK_IDLE)  err = VIO_TRP;
                else if (!rrd_ok_i)   err = VIO_TRRD;
                else begin
                    act_fire  = 1'b1;
                    d.st      = BK_ACTIVE;
                    d.act_cnt = CW'(1);
                    d.ap      = 1'b0;
                end
            end else if (is_col) begin
                if (q.st != BK_ACTIVE || q.ap) err = VIO_CLOSED;
                else if (q.act_cnt < RCD_C)     err = VIO_TRCD;
                else if (is_auto) begin
                    d.ap      = 1'b1;
                    d.bst_cnt = BL_M1_C;
                end
            end else if (cmd_i == CMD_PRE) begin
                if (q.st == BK_ACTIVE && !q.ap) begin
                    if (q.act_cnt < RASMIN_C) err = VIO_RASMIN;
                    else                      start_pre = 1'b1;
                end
            end
        end

        if (q.st == BK_ACTIVE && q.ap && q.bst_cnt == '0 && q.act_cnt >= RASMIN_C)
            start_pre = 1'b1;

        if (start_pre) begin
            d.st      = CLOSE_ST;
            d.pre_cnt = CW'(1);
            d.ap      = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '{st: BK_IDLE, ap: 1'b0, act_cnt: SAT_C, pre_cnt: SAT_C, bst_cnt: '0};
        else       q <= d;
    end

    assign act_rdy_o  = (q.st == BK_IDLE) && rrd_ok_i;
    assign col_rdy_o  = (q.st == BK_ACTIVE) && !q.ap && (q.act_cnt >= RCD_C);
    assign pre_rdy_o  = (q.st == BK_ACTIVE) && !q.ap && (q.act_cnt >= RASMIN_C);
    assign err_o      = err;
    assign act_fire_o = act_fire;
    assign ras_over_o = (q.st == BK_ACTIVE) && (q.act_cnt == RASMAX_C);

    AST_ACT_AFTER_RP: assert property (@(posedge clk_i) disable iff (rst_i)
        act_fire_o |-> (q.pre_cnt >= RP_C)); // R2

    AST_CLOSE_AFTER_RASMIN: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.st == BK_ACTIVE && d.st != BK_ACTIVE) |-> (q.act_cnt >= RASMIN_C)); // R5

    AST_RASMAX_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
        ras_over_o |=> !ras_over_o); // R6

endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
    import sdt_pkg::*;
#(
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RRD     = 2,
    parameter int unsigned T_RAS_MIN = 8,
    parameter int unsigned T_RAS_MAX = 40,
    parameter int unsigned T_RCD     = 3,
    parameter int unsigned BURST_LEN = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] cmd_i,
    input  logic       bank_i,
    output logic [1:0] act_rdy_o,
    output logic [1:0] col_rdy_o,
    output logic [1:0] pre_rdy_o,
    output logic       viol_o,
    output logic [2:0] viol_code_o,
    output logic       viol_bank_o
);
    localparam int unsigned N_BANKS = 2;
    localparam int unsigned M1   = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int unsigned M2   = (M1 > BURST_LEN) ? M1 : BURST_LEN;
    localparam int unsigned M3   = (M2 > T_RAS_MIN) ? M2 : T_RAS_MIN;
    localparam int unsigned MAXT = (M3 > T_RAS_MAX + 1) ? M3 : T_RAS_MAX + 1;
    localparam int unsigned CW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic       flag;
        logic [2:0] code;
        logic       bank;
    } vio_t;

    vio_t vq, vd;
    logic [2:0] bank_err [N_BANKS];
    logic [N_BANKS-1:0] act_fire, ras_over;
    logic rrd_ok, act_any;

    assign act_any = |act_fire;

    sdt_rrd_gap #(.T_RRD(T_RRD)) u_gap (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .act_fire_i (act_any),
        .ok_o       (rrd_ok)
    );

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        sdt_bank #(
            .T_RP      (T_RP),
            .T_RAS_MIN (T_RAS_MIN),
            .T_RAS_MAX (T_RAS_MAX),
            .T_RCD     (T_RCD),
            .BURST_LEN (BURST_LEN),
            .CW        (CW)
        ) u_bank (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .cmd_i      (cmd_i),
            .sel_i      (bank_i == 1'(g)),
            .rrd_ok_i   (rrd_ok),
            .act_rdy_o  (act_rdy_o[g]),
            .col_rdy_o  (col_rdy_o[g]),
            .pre_rdy_o  (pre_rdy_o[g]),
            .err_o      (bank_err[g]),
            .act_fire_o (act_fire[g]),
            .ras_over_o (ras_over[g])
        );
    end

    always_comb begin
        vd = '0;
        if (bank_err[bank_i] != VIO_NONE) begin
            vd.flag = 1'b1;
            vd.code = bank_err[bank_i];
            vd.bank = bank_i;
        end else if (ras_over[0]) begin
            vd.flag = 1'b1;
            vd.code = VIO_RASMAX;
            vd.bank = 1'b0;
        end else if (ras_over[1]) begin
            vd.flag = 1'b1;
            vd.code = VIO_RASMAX;
            vd.bank = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) vq <= '0;
        else       vq <= vd;
    end

    assign viol_o      = vq.flag;
    assign viol_code_o = vq.code;
    assign viol_bank_o = vq.bank;

    AST_CODE_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        !viol_o |-> (viol_code_o == 3'd0 && !viol_bank_o)); // R10

    AST_COL_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        ((cmd_i == CMD_RD || cmd_i == CMD_WR || cmd_i == CMD_RDA || cmd_i == CMD_WRA)
         && !col_rdy_o[bank_i]) |=> viol_o); // R4

    if (T_RRD > 1) begin : g_spacing
        AST_ACT_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
            act_any |=> !act_any); // R3
    end

endmodule

// File: tb/tb_sdram_row_tracker.sv
`timescale 1ns/1ps
module tb_sdram_row_tracker;
    localparam int T_RP = 3, T_RRD = 2, T_RAS_MIN = 8, T_RAS_MAX = 40, T_RCD = 3, BL = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cmd;
    logic       bank;
    logic [1:0] act_rdy, col_rdy, pre_rdy;
    logic       viol, viol_bank;
    logic [2:0] viol_code;

    always #5 clk = ~clk;

    sdram_row_tracker #(
        .T_RP(T_RP), .T_RRD(T_RRD), .T_RAS_MIN(T_RAS_MIN),
        .T_RAS_MAX(T_RAS_MAX), .T_RCD(T_RCD), .BURST_LEN(BL)
    ) dut (
        .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .bank_i(bank),
        .act_rdy_o(act_rdy), .col_rdy_o(col_rdy), .pre_rdy_o(pre_rdy),
        .viol_o(viol), .viol_code_o(viol_code), .viol_bank_o(viol_bank)
    );

    // behavioural model: 0 closed, 1 open, 2 closing
    int st [2], act_t [2], pre_t [2], ap [2], ap_t [2];
    int last_act, cyc;
    int e_flag, e_code, e_bank;
    int vectors = 0, fails = 0;
    bit done = 0;

    task automatic chk(input string tag, input string f, input int got, input int exp);
        if (got != exp) begin
            fails++;
            $display("FAIL %s cycle %0d %s: got %0d expected %0d", tag, cyc, f, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            st[b] = 0; act_t[b] = -1000; pre_t[b] = -1000; ap[b] = 0; ap_t[b] = -1000;
        end
        last_act = -1000; cyc = 0; e_flag = 0; e_code = 0; e_bank = 0;
    endtask

    task automatic step(input int c, input int b, input string tag);
        int err, ras[2], trig[2];
        @(negedge clk);
        cmd = 3'(c); bank = 1'(b);
        #1;
        for (int k = 0; k < 2; k++)
            if (st[k] == 2 && cyc - pre_t[k] >= T_RP) st[k] = 0;
        vectors++;
        for (int k = 0; k < 2; k++) begin
            chk(tag, $sformatf("act_rdy[%0d]", k), int'(act_rdy[k]),
                int'(st[k] == 0 && cyc - last_act >= T_RRD));
            chk(tag, $sformatf("col_rdy[%0d]", k), int'(col_rdy[k]),
                int'(st[k] == 1 && ap[k] == 0 && cyc - act_t[k] >= T_RCD));
            chk(tag, $sformatf("pre_rdy[%0d]", k), int'(pre_rdy[k]),
                int'(st[k] == 1 && ap[k] == 0 && cyc - act_t[k] >= T_RAS_MIN));
        end
        chk(tag, "viol", int'(viol), e_flag);
        chk(tag, "viol_code", int'(viol_code), e_code);
        chk(tag, "viol_bank", int'(viol_bank), e_bank);
        // next-state
        for (int k = 0; k < 2; k++) begin
            ras[k]  = int'(st[k] == 1 && cyc - act_t[k] == T_RAS_MAX);
            trig[k] = int'(st[k] == 1 && ap[k] == 1 && cyc >= ap_t[k] + BL &&
                           cyc - act_t[k] >= T_RAS_MIN);
        end
        err = 0;
        if (c == 1) begin
            if (st[b] != 0) err = 1;
            else if (cyc - last_act < T_RRD) err = 2;
            else begin st[b] = 1; act_t[b] = cyc; ap[b] = 0; last_act = cyc; end
        end else if (c >= 2 && c <= 5) begin
            if (st[b] != 1 || ap[b] != 0) err = 6;
            else if (cyc - act_t[b] < T_RCD) err = 5;
            else if (c >= 4) begin ap[b] = 1; ap_t[b] = cyc; end
        end else if (c == 6) begin
            if (st[b] == 1 && ap[b] == 0) begin
                if (cyc - act_t[b] < T_RAS_MIN) err = 3;
                else begin st[b] = 2; pre_t[b] = cyc; end
            end
        end
        for (int k = 0; k < 2; k++)
            if (trig[k] != 0) begin st[k] = 2; pre_t[k] = cyc; ap[k] = 0; end
        if (err != 0)          begin e_flag = 1; e_code = err; e_bank = b; end
        else if (ras[0] != 0)  begin e_flag = 1; e_code = 4;   e_bank = 0; end
        else if (ras[1] != 0)  begin e_flag = 1; e_code = 4;   e_bank = 1; end
        else                   begin e_flag = 0; e_code = 0;   e_bank = 0; end
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd = 3'd0; bank = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        chk("R1", "act_rdy (in reset)", int'(act_rdy), 3);
        chk("R1", "col_rdy (in reset)", int'(col_rdy), 0);
        chk("R1", "pre_rdy (in reset)", int'(pre_rdy), 0);
        chk("R1", "viol (in reset)", int'(viol), 0);
        @(negedge clk); rst = 1'b0;
        model_reset();
        idle(3, "R1");
        // R3: activate spacing across banks
        step(1, 0, "R3"); step(1, 1, "R3"); step(0, 0, "R3"); step(1, 1, "R3");
        // R4: row-to-column delay on bank 1
        step(2, 1, "R4"); idle(1, "R4"); step(3, 1, "R4");
        // R5: precharge too early, then legal
        step(6, 1, "R5"); idle(4, "R5"); step(6, 1, "R5");
        // R2: activate to closing and to open bank, then after T_RP
        step(1, 1, "R2"); step(1, 0, "R2"); idle(2, "R2"); step(1, 1, "R2");
        // R8: precharge to closed bank, R7: column command to closed bank
        step(6, 0, "R5"); idle(T_RP, "R8"); step(6, 0, "R8"); step(2, 0, "R7");
        // R11: code 7 behaves as no-op
        step(7, 0, "R11"); step(7, 1, "R11");
        // R9: auto-precharge where T_RAS_MIN dominates (bank 0)
        step(1, 0, "R9"); idle(2, "R9"); step(4, 0, "R9");
        step(2, 0, "R7"); step(6, 0, "R8"); idle(12, "R9");
        // R9: auto-precharge where burst end dominates (bank 0)
        step(1, 0, "R9"); idle(6, "R9"); step(5, 0, "R9"); idle(12, "R9");
        // R6 and R10: open too long on bank 0, command error on bank 1 in the same cycle
        idle(5, "R6");
        step(6, 1, "R6"); idle(T_RP + 2, "R6");
        step(1, 0, "R6"); idle(T_RAS_MAX - 1, "R6"); step(2, 1, "R10");
        idle(3, "R6");
        // R6: bank 1 alone goes over
        step(1, 1, "R6"); idle(T_RAS_MAX + 3, "R6");
        step(6, 0, "R10"); step(6, 1, "R10"); idle(6, "R10");
        // mixed traffic
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 8) step(0, int'($urandom % 2), "R10");
            else       step(r - 8, int'($urandom % 2), "R10");
        end
        idle(4, "R10");
        finish_run();
    end

endmodule